// File: doc/BRIEF.md
# Fused Speed-Grade Selector

This block turns a fused configuration word into the highest operating speed the part may run at. The word holds two speed fields, one for the processor core and one for the rest of the device. Each field is a set of flags, one per speed grade. Each field is first masked with a constant set of grades that this lane supports. The highest-numbered flag that survives the mask picks an entry from a fixed ten-entry speed table. The table is not monotonic: it rises from 1000 MHz to 1500 MHz at index 4, then falls back to 800 MHz at index 9.

When no flag survives, the lane reports a floor speed. That floor is 800 MHz on the normal variant and 200 MHz on the low-end variant, chosen by a static select input. A caller presents the word with a one-cycle valid strobe. Both speeds appear one clock later as 12-bit MHz values, together with a one-cycle done pulse, and they hold until the next strobe.

Top module: `spd_grade_sel`

## Requirements
- R1: While reset is asserted and after it is released, `core_mhz`, `dev_mhz` and `done` are all zero until the first strobe.
- R2: `done` is high in exactly the cycles that directly follow a cycle with `req_valid` high, and in no other cycle.
- R3: The device field is fuse bits [DEV_LSB+9:DEV_LSB] (default bits 9:0). The core field is fuse bits [CORE_LSB+9:CORE_LSB] (default bits 25:16). In each field, bit k is the flag for speed index k.
- R4: Among the flags that are set in the field and also in the supported mask, the one with the highest index wins.
- R5: The speed table for indices 0..9 is 1000, 1200, 1350, 1400, 1500, 1400, 1350, 1200, 1000, 800 MHz. The output is the entry at the winning index.
- R6: If no flag survives the mask, the output is 800 MHz when `lowend_sel` is 0 and 200 MHz when it is 1.
- R7: Flags outside the supported mask have no effect. The default core mask is 10'h3DF (index 5 not supported). The default device mask is 10'h1F7 (indices 3 and 9 not supported).
- R8: While `req_valid` is low, `core_mhz` and `dev_mhz` keep their last values, even if the fuse word changes.
- R9: Fuse bits outside both fields have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Strobe: evaluate `fuse_word` this cycle |
| fuse_word | input | FUSE_W (32) | Fused configuration word |
| lowend_sel | input | 1 | Static variant select: 1 makes the floor 200 MHz |
| core_mhz | output | 12 | Core speed in MHz, registered |
| dev_mhz | output | 12 | Device speed in MHz, registered |
| done | output | 1 | One-cycle pulse with fresh results |

## Verification
Some properties are checked by assertions on every cycle. These are the strobe-to-done timing, the holding of results between strobes, and that each reported speed is either a table entry or the variant floor. They also check that every lane's winning index points at a supported, set flag. The remaining behaviours can only be shown by the bench's sweeps: field placement, priority among several flags, the exact table value at each index, and the masking of unsupported and out-of-field bits. Those sweeps cover every single-flag pattern, the empty pattern, patterns with only unsupported flags, and a set of multi-flag words, on both variants.

// File: rtl/spd_grade_pkg.sv
package spd_grade_pkg;
    localparam int NSPD  = 10;
    localparam int IDX_W = $clog2(NSPD);
    localparam int MHZ_W = 12;

    typedef logic [MHZ_W-1:0] mhz_t;

    typedef struct packed {
        mhz_t core;
        mhz_t dev;
        logic done;
    } sel_state_t;

    // Speed grade per flag index; rises then falls, so no ordering by value
    function automatic mhz_t grade_mhz(input logic [IDX_W-1:0] idx);
        case (idx)
            4'd0:    grade_mhz = 12'd1000;
            4'd1:    grade_mhz = 12'd1200;
            4'd2:    grade_mhz = 12'd1350;
            4'd3:    grade_mhz = 12'd1400;
            4'd4:    grade_mhz = 12'd1500;
            4'd5:    grade_mhz = 12'd1400;
            4'd6:    grade_mhz = 12'd1350;
            4'd7:    grade_mhz = 12'd1200;
            4'd8:    grade_mhz = 12'd1000;
            default: grade_mhz = 12'd800;
        endcase
    endfunction
endpackage

// File: rtl/spd_field_pick.sv
module spd_field_pick
    import spd_grade_pkg::*;
#(
    parameter int              FUSE_W = 32,
    parameter int              LSB    = 0,
    parameter logic [NSPD-1:0] SUP    = '1
) (
    input  logic [FUSE_W-1:0] fuse,
    output logic [NSPD-1:0]   surv
);
    // R3 field slice, R7 supported mask
    always_comb begin
        surv = fuse[LSB +: NSPD] & SUP;
    end
endmodule

// File: rtl/spd_prio_find.sv
module spd_prio_find
    import spd_grade_pkg::*;
(
    input  logic [NSPD-1:0]  vec,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    // R4: ascending scan, later (higher) indices override earlier ones
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = 0; k < NSPD; k++) begin
            if (vec[k]) begin
                hit = 1'b1;
                idx = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/spd_lane.sv
module spd_lane
    import spd_grade_pkg::*;
#(
    parameter int              FUSE_W  = 32,
    parameter int              LSB     = 0,
    parameter logic [NSPD-1:0] SUP     = '1,
    parameter int              FLOOR_N = 800,
    parameter int              FLOOR_L = 200
) (
    input  logic [FUSE_W-1:0] fuse,
    input  logic              lowend,
    output mhz_t              mhz,
    output logic [NSPD-1:0]   surv,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    spd_field_pick #(.FUSE_W(FUSE_W), .LSB(LSB), .SUP(SUP)) u_pick (
        .fuse (fuse),
        .surv (surv)
    );

    spd_prio_find u_find (
        .vec (surv),
        .hit (hit),
        .idx (idx)
    );

    // R5 table lookup, R6 variant floor
    always_comb begin
        if (hit)         mhz = grade_mhz(idx);
        else if (lowend) mhz = MHZ_W'(FLOOR_L);
        else             mhz = MHZ_W'(FLOOR_N);
    end
endmodule

// File: rtl/spd_grade_sel.sv
module spd_grade_sel
    import spd_grade_pkg::*;
#(
    parameter int              FUSE_W   = 32,
    parameter int              DEV_LSB  = 0,
    parameter int              CORE_LSB = 16,
    parameter logic [NSPD-1:0] DEV_SUP  = 10'h1F7,
    parameter logic [NSPD-1:0] CORE_SUP = 10'h3DF,
    parameter int              FLOOR_N  = 800,
    parameter int              FLOOR_L  = 200
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [FUSE_W-1:0] fuse_word,
    input  logic              lowend_sel,
    output logic [MHZ_W-1:0]  core_mhz,
    output logic [MHZ_W-1:0]  dev_mhz,
    output logic              done
);
    localparam int NLANE = 2;  // lane 0 = device, lane 1 = core
    localparam int              LANE_LSB [NLANE] = '{DEV_LSB, CORE_LSB};
    localparam logic [NSPD-1:0] LANE_SUP [NLANE] = '{DEV_SUP, CORE_SUP};

    mhz_t             lane_mhz  [NLANE];
    logic [NSPD-1:0]  lane_surv [NLANE];
    logic             lane_hit  [NLANE];
    logic [IDX_W-1:0] lane_idx  [NLANE];

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        spd_lane #(
            .FUSE_W  (FUSE_W),
            .LSB     (LANE_LSB[g]),
            .SUP     (LANE_SUP[g]),
            .FLOOR_N (FLOOR_N),
            .FLOOR_L (FLOOR_L)
        ) u_lane (
            .fuse   (fuse_word),
            .lowend (lowend_sel),
            .mhz    (lane_mhz[g]),
            .surv   (lane_surv[g]),
            .hit    (lane_hit[g]),
            .idx    (lane_idx[g])
        );

        // R4: a winning index always names a surviving flag, none above it
        a_r4_win_is_top: assert property (@(posedge clk) disable iff (!rst_n)
            lane_hit[g] |-> (lane_surv[g][lane_idx[g]] &&
                             ((lane_surv[g] >> lane_idx[g]) == NSPD'(1))));
        // R7: survivors never include unsupported flags
        a_r7_mask_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (lane_surv[g] & ~LANE_SUP[g]) == '0);
    end

    sel_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = req_valid;
        if (req_valid) begin
            st_d.dev  = lane_mhz[0];
            st_d.core = lane_mhz[1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign core_mhz = st_q.core;
    assign dev_mhz  = st_q.dev;
    assign done     = st_q.done;

    function automatic logic legal_mhz(input mhz_t v, input logic le);
        legal_mhz = (v == 12'd1000) || (v == 12'd1200) || (v == 12'd1350) ||
                    (v == 12'd1400) || (v == 12'd1500) || (v == 12'd800) ||
                    (le && v == MHZ_W'(FLOOR_L));
    endfunction

    // R2: strobe gives a pulse next cycle, and only a strobe does
    a_r2_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    a_r2_no_spurious_done: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !done);
    // R8: results hold between strobes
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(core_mhz) && $stable(dev_mhz)));
    // R5/R6: a reported speed is a table entry or the variant floor
    a_r5_legal_value: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (legal_mhz(core_mhz, lowend_sel) && legal_mhz(dev_mhz, lowend_sel)));
endmodule

// File: tb/spd_grade_sel_bench.sv
module spd_grade_sel_bench;
    localparam int        DLSB = 0;
    localparam int        CLSB = 16;
    localparam logic [9:0] DSUP = 10'h1F7;
    localparam logic [9:0] CSUP = 10'h3DF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] fuse_word = '0;
    logic        lowend_sel = 1'b0;
    logic [11:0] core_mhz, dev_mhz;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;  // 125 MHz

    spd_grade_sel u_spd_grade_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .fuse_word  (fuse_word),
        .lowend_sel (lowend_sel),
        .core_mhz   (core_mhz),
        .dev_mhz    (dev_mhz),
        .done       (done)
    );

    function automatic int tbl(input int k);
        case (k)
            0: tbl = 1000; 1: tbl = 1200; 2: tbl = 1350; 3: tbl = 1400;
            4: tbl = 1500; 5: tbl = 1400; 6: tbl = 1350; 7: tbl = 1200;
            8: tbl = 1000; default: tbl = 800;
        endcase
    endfunction

    function automatic int expect_mhz(input logic [9:0] fld, input logic [9:0] sup,
                                      input logic le);
        for (int k = 9; k >= 0; k--)
            if (fld[k] && sup[k]) return tbl(k);
        return le ? 200 : 800;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Strobe one word, then sample results one cycle later (R2/R3..R7)
    task automatic apply(input logic [31:0] w, input logic le, input string req);
        int ed, ec;
        @(negedge clk);
        fuse_word  = w;
        lowend_sel = le;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        ed = expect_mhz(w[DLSB +: 10], DSUP, le);
        ec = expect_mhz(w[CLSB +: 10], CSUP, le);
        check({req, " dev"},  int'(dev_mhz),  ed);
        check({req, " core"}, int'(core_mhz), ec);
        check("R2 done pulse", int'(done), 1);
    endtask

    initial begin
        logic [31:0] lfsr;
        int hd, hc;
        repeat (3) @(negedge clk);
        check("R1 reset core", int'(core_mhz), 0);
        check("R1 reset dev",  int'(dev_mhz),  0);
        check("R1 reset done", int'(done),     0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release done", int'(done), 0);
        check("R1 after release core", int'(core_mhz), 0);

        for (int le = 0; le < 2; le++) begin
            // every single flag in each field (R3, R5, R7)
            for (int b = 0; b < 10; b++) begin
                apply(32'(1) << (DLSB + b), le[0], "R5 single dev flag");
                apply(32'(1) << (CLSB + b), le[0], "R3 single core flag");
            end
            // empty fields -> floor (R6)
            apply(32'h0, le[0], "R6 empty");
            // only unsupported flags -> floor (R7)
            apply((32'(~DSUP & 10'h3FF) << DLSB) | (32'(~CSUP & 10'h3FF) << CLSB),
                  le[0], "R7 unsupported only");
            // bits outside both fields -> floor (R9)
            apply(32'hFC00_FC00, le[0], "R9 outside fields");
            // highest surviving flag wins over lower ones (R4)
            apply(32'h0021_0228, le[0], "R4 priority");
        end

        // multi-flag words from an LFSR (R4, R5, R7, R9)
        lfsr = 32'hACE1_1234;
        for (int i = 0; i < 40; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            apply(lfsr, lfsr[7], "R4 mixed word");
        end

        // hold between strobes while the word changes (R8, R2)
        apply(32'h0010_0010, 1'b0, "R8 setup");
        hd = int'(dev_mhz);
        hc = int'(core_mhz);
        for (int i = 0; i < 3; i++) begin
            fuse_word = 32'h0001_0001 << i;
            @(negedge clk);
            check("R8 hold dev",  int'(dev_mhz),  hd);
            check("R8 hold core", int'(core_mhz), hc);
            check("R2 no done without strobe", int'(done), 0);
        end

        finished = 1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule